// File: doc/BRIEF.md
# Mezzanine Slot Space Decoder

This block sits behind a 1 KiB host-side local window and turns each host access into a request to one of four mezzanine module slots. Every slot exposes three sub-spaces: I/O, identification and interrupt. The block splits the host address into a slot number, a sub-space and an offset, and sends a one-cycle strobe to the addressed slot. It then returns the slot's read data to the host with a one-cycle valid.

Reads at two fixed interrupt-space locations also acknowledge a level-sensitive interrupt line of that slot. Accesses to empty slots, and accesses whose size is not byte or halfword, are completed inside the block. An optional big-endian mode changes the byte address and swaps halfword data lanes.

Top module: `mezz_slot_decoder`

## Requirements
- R1: A request is accepted in the cycle `req_valid` is high at a rising clock edge. After the next edge, exactly one bit of `slot_req` is high for one cycle. The bit index is the slot number, taken from address bits 9:8 after any endian adjustment.
- R2: Address bits 7:6 select the sub-space. The value 2 gives `slot_space` = 1 (identification), the value 3 gives `slot_space` = 2 (interrupt), and the values 0 and 1 give `slot_space` = 0 (I/O).
- R3: `slot_offset` carries address bits 6:0 for I/O-space accesses. For identification and interrupt accesses it carries address bits 5:0, with bit 6 forced to zero.
- R4: A read sets `rsp_valid` high for one cycle, one cycle after its slot strobe. `rsp_data` then carries the addressed slot's `slot_rdata` lane. Writes drive `slot_write` high and pass `slot_wdata`, and never raise `rsp_valid`.
- R5: `irq_ack` bit 2*slot+line pulses together with the slot strobe when all of these hold:
  - the access is a read in the interrupt space;
  - the offset is 0 (line 0) or 2 (line 1);
  - `irq_status` at that bit index is set;
  - `irq_edge` at that bit index is clear, meaning the line is level-sensitive.
- R6: An access to a slot whose `slot_present` bit is low raises no strobe and no acknowledge. A read of such a slot returns `rsp_data` = 0 with `rsp_valid`.
- R7: `req_size` 0 means byte and 1 means halfword. A request with size 2 or 3 raises no strobe and no acknowledge. If it is a read, it returns zero with `rsp_valid`.
- R8: When `big_endian` is high, a byte access has address bit 0 inverted before decoding.
- R9: When `big_endian` is high, a halfword access has its two data bytes swapped, both on `slot_wdata` and on `rsp_data`. `slot_half` reports a halfword access.
- R10: While `rst_n` is low, any pending request is dropped and `slot_req`, `irq_ack` and `rsp_valid` are low. None of them pulses after reset is released until a new request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, others rejected |
| req_addr | input | 10 | Window byte address |
| req_wdata | input | 16 | Host write data |
| big_endian | input | 1 | Big-endian mode for this window |
| slot_present | input | 4 | Module fitted, one bit per slot |
| irq_status | input | 8 | Interrupt status, bit 2*slot+line |
| irq_edge | input | 8 | 1 = edge-sensitive line, same indexing |
| slot_rdata | input | 64 | Per-slot read data, 16 bits per slot |
| slot_req | output | 4 | One-hot slot strobe |
| slot_space | output | 2 | 0 I/O, 1 identification, 2 interrupt |
| slot_offset | output | 7 | Offset within the sub-space |
| slot_write | output | 1 | Strobe is a write |
| slot_half | output | 1 | Strobe is a halfword access |
| slot_wdata | output | 16 | Write data after lane handling |
| irq_ack | output | 8 | Level interrupt acknowledge pulses |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 16 | Read response data |

## Verification
The bench sweeps every window address, in both endian modes and with all four size codes, and checks the decode against arithmetic expectations. The sweep catches a design that takes the offset with the wrong width in the identification or interrupt space, since such a design would leak address bit 6 into the offset. It also catches a design that flips the address on halfword accesses or swaps data on byte accesses. Directed cases target the acknowledge rule: an edge-sensitive line, a clear status bit, offset 1 and a write must each leave `irq_ack` low. A design that ignored `slot_present` or the size code would strobe an empty slot, or return stale data instead of zero.

// File: rtl/mezz_pkg.sv
package mezz_pkg;
  typedef enum logic [1:0] {
    SP_IO  = 2'd0,
    SP_ID  = 2'd1,
    SP_INT = 2'd2
  } space_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] RAW_ID  = 2'd2;
  localparam logic [1:0] RAW_INT = 2'd3;
endpackage

// File: rtl/mezz_addr_split.sv
module mezz_addr_split
  import mezz_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int SLOT_W = 2,
  parameter int OFF_W  = 7
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              byte_flip,
  output logic [SLOT_W-1:0] slot,
  output space_e            space,
  output logic [OFF_W-1:0]  offset,
  output logic              ack_hit,
  output logic              ack_line
);
  localparam int SUB_OFF_W = OFF_W - 1;

  logic [ADDR_W-1:0] eff;
  logic [1:0]        raw;

  always_comb begin
    eff      = addr ^ {{(ADDR_W-1){1'b0}}, byte_flip};
    slot     = eff[ADDR_W-1 -: SLOT_W];
    raw      = eff[SUB_OFF_W+1 -: 2];
    ack_hit  = 1'b0;
    ack_line = 1'b0;
    case (raw)
      RAW_ID:  space = SP_ID;
      RAW_INT: space = SP_INT;
      default: space = SP_IO;
    endcase
    if (space == SP_IO) begin
      offset = eff[OFF_W-1:0];
    end else begin
      offset = {1'b0, eff[SUB_OFF_W-1:0]};
    end
    if (space == SP_INT) begin
      ack_hit  = (eff[SUB_OFF_W-1:2] == '0) && (eff[0] == 1'b0);
      ack_line = eff[1];
    end
  end
endmodule

// File: rtl/mezz_lane_swap.sv
module mezz_lane_swap #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] din,
  input  logic              swap,
  output logic [DATA_W-1:0] dout
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] swapped;

  for (genvar i = 0; i < 2; i++) begin : g_lane
    assign swapped[i*HALF +: HALF] = din[(1-i)*HALF +: HALF];
  end

  assign dout = swap ? swapped : din;
endmodule

// File: rtl/mezz_ack_gen.sv
module mezz_ack_gen #(
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_W    = 2
) (
  input  logic                   enable,
  input  logic [SLOT_W-1:0]      slot,
  input  logic                   line,
  input  logic [2*NUM_SLOTS-1:0] status,
  input  logic [2*NUM_SLOTS-1:0] edge_sel,
  output logic [2*NUM_SLOTS-1:0] ack
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    for (genvar l = 0; l < 2; l++) begin : g_line
      assign ack[2*s+l] = enable && (slot == SLOT_W'(s)) && (line == l[0])
                          && status[2*s+l] && !edge_sel[2*s+l];
    end
  end
endmodule

// File: rtl/mezz_slot_decoder.sv
module mezz_slot_decoder
  import mezz_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int DATA_W    = 16,
  parameter int OFF_W     = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [1:0]                  req_size,
  input  logic [$clog2(NUM_SLOTS)+7:0] req_addr,
  input  logic [DATA_W-1:0]           req_wdata,
  input  logic                        big_endian,
  input  logic [NUM_SLOTS-1:0]        slot_present,
  input  logic [2*NUM_SLOTS-1:0]      irq_status,
  input  logic [2*NUM_SLOTS-1:0]      irq_edge,
  input  logic [NUM_SLOTS*DATA_W-1:0] slot_rdata,
  output logic [NUM_SLOTS-1:0]        slot_req,
  output logic [1:0]                  slot_space,
  output logic [OFF_W-1:0]            slot_offset,
  output logic                        slot_write,
  output logic                        slot_half,
  output logic [DATA_W-1:0]           slot_wdata,
  output logic [2*NUM_SLOTS-1:0]      irq_ack,
  output logic                        rsp_valid,
  output logic [DATA_W-1:0]           rsp_data
);
  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int ADDR_W = SLOT_W + 8;
  localparam int ACK_W  = 2 * NUM_SLOTS;

  // decode of the incoming request
  logic [SLOT_W-1:0] dec_slot;
  space_e            dec_space;
  logic [OFF_W-1:0]  dec_off;
  logic              dec_ack_hit;
  logic              dec_ack_line;
  logic              byte_flip;
  logic              size_ok;
  logic              hit;
  logic [DATA_W-1:0] wdata_sw;
  logic [ACK_W-1:0]  ack_vec;

  // stage 1: slot strobe
  logic [NUM_SLOTS-1:0] q_req,      n_req;
  logic [1:0]           q_space,    n_space;
  logic [OFF_W-1:0]     q_off,      n_off;
  logic                 q_write,    n_write;
  logic                 q_half,     n_half;
  logic [DATA_W-1:0]    q_wdata,    n_wdata;
  logic [SLOT_W-1:0]    q_slot,     n_slot;
  logic                 q_swap_rd,  n_swap_rd;
  logic [ACK_W-1:0]     q_ack,      n_ack;
  logic                 q_rd_pend,  n_rd_pend;
  logic                 q_rd_live,  n_rd_live;
  logic                 cap_en;

  // stage 2: response
  logic                 q_rsp_v,    n_rsp_v;
  logic [DATA_W-1:0]    q_rsp_d,    n_rsp_d;
  logic [DATA_W-1:0]    rd_sel;
  logic [DATA_W-1:0]    rd_sw;

  assign byte_flip = big_endian && (req_size == SZ_BYTE);
  assign size_ok   = (req_size == SZ_BYTE) || (req_size == SZ_HALF);

  mezz_addr_split #(
    .ADDR_W (ADDR_W),
    .SLOT_W (SLOT_W),
    .OFF_W  (OFF_W)
  ) u_split (
    .addr      (req_addr[ADDR_W-1:0]),
    .byte_flip (byte_flip),
    .slot      (dec_slot),
    .space     (dec_space),
    .offset    (dec_off),
    .ack_hit   (dec_ack_hit),
    .ack_line  (dec_ack_line)
  );

  mezz_lane_swap #(.DATA_W(DATA_W)) u_wswap (
    .din  (req_wdata),
    .swap (big_endian && (req_size == SZ_HALF)),
    .dout (wdata_sw)
  );

  mezz_ack_gen #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_ack (
    .enable   (hit && !req_write && dec_ack_hit),
    .slot     (dec_slot),
    .line     (dec_ack_line),
    .status   (irq_status),
    .edge_sel (irq_edge),
    .ack      (ack_vec)
  );

  assign rd_sel = slot_rdata[q_slot*DATA_W +: DATA_W];

  mezz_lane_swap #(.DATA_W(DATA_W)) u_rswap (
    .din  (rd_sel),
    .swap (q_swap_rd),
    .dout (rd_sw)
  );

  // next-state logic
  always_comb begin
    hit       = req_valid && size_ok && slot_present[dec_slot];
    cap_en    = req_valid;
    n_req     = '0;
    if (hit) n_req[dec_slot] = 1'b1;
    n_ack     = ack_vec;
    n_rd_pend = req_valid && !req_write;
    n_rd_live = hit && !req_write;
    n_space   = q_space;
    n_off     = q_off;
    n_write   = q_write;
    n_half    = q_half;
    n_wdata   = q_wdata;
    n_slot    = q_slot;
    n_swap_rd = q_swap_rd;
    if (cap_en) begin
      n_space   = dec_space;
      n_off     = dec_off;
      n_write   = req_write;
      n_half    = (req_size == SZ_HALF);
      n_wdata   = wdata_sw;
      n_slot    = dec_slot;
      n_swap_rd = big_endian && (req_size == SZ_HALF);
    end
    n_rsp_v = q_rd_pend;
    n_rsp_d = q_rsp_d;
    if (q_rd_pend) begin
      n_rsp_d = q_rd_live ? rd_sw : '0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_req     <= '0;
      q_ack     <= '0;
      q_rd_pend <= 1'b0;
      q_rd_live <= 1'b0;
      q_space   <= '0;
      q_off     <= '0;
      q_write   <= 1'b0;
      q_half    <= 1'b0;
      q_wdata   <= '0;
      q_slot    <= '0;
      q_swap_rd <= 1'b0;
      q_rsp_v   <= 1'b0;
      q_rsp_d   <= '0;
    end else begin
      q_req     <= n_req;
      q_ack     <= n_ack;
      q_rd_pend <= n_rd_pend;
      q_rd_live <= n_rd_live;
      q_space   <= n_space;
      q_off     <= n_off;
      q_write   <= n_write;
      q_half    <= n_half;
      q_wdata   <= n_wdata;
      q_slot    <= n_slot;
      q_swap_rd <= n_swap_rd;
      q_rsp_v   <= n_rsp_v;
      q_rsp_d   <= n_rsp_d;
    end
  end

  assign slot_req    = q_req;
  assign slot_space  = q_space;
  assign slot_offset = q_off;
  assign slot_write  = q_write;
  assign slot_half   = q_half;
  assign slot_wdata  = q_wdata;
  assign irq_ack     = q_ack;
  assign rsp_valid   = q_rsp_v;
  assign rsp_data    = q_rsp_d;
endmodule

// File: rtl/mezz_slot_decoder_chk.sv
module mezz_slot_decoder_chk #(
  parameter int NUM_SLOTS = 4,
  parameter int DATA_W    = 16,
  parameter int OFF_W     = 7
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        req_valid,
  input logic                        req_write,
  input logic [1:0]                  req_size,
  input logic [NUM_SLOTS-1:0]        slot_present,
  input logic [NUM_SLOTS-1:0]        slot_req,
  input logic [1:0]                  slot_space,
  input logic [OFF_W-1:0]            slot_offset,
  input logic                        slot_write,
  input logic [2*NUM_SLOTS-1:0]      irq_ack,
  input logic                        rsp_valid
);
  // R1: at most one slot strobed at a time
  p_onehot_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_req));

  // R1: a strobe only follows an accepted byte or halfword request
  p_strobe_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req != '0) |-> $past(req_valid) && ($past(req_size) < 2'd2));

  // R3: sub-space offsets never use bit 6
  p_sub_offset_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req != '0 && slot_space != 2'd0) |-> (slot_offset[OFF_W-1] == 1'b0));

  // R4: a response appears exactly two edges after a read request
  p_rsp_timing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == ($past(req_valid, 2) && !$past(req_write, 2)));

  // R5: acknowledges only ride on an interrupt-space read strobe
  p_ack_with_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack != '0) |-> (slot_req != '0) && !slot_write && (slot_space == 2'd2)
                        && ($countones(irq_ack) == 1));

  // R6: no strobe reaches an empty slot
  p_absent_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req != '0) |-> ((slot_req & ~$past(slot_present)) == '0));

  // R10: outputs quiet on the first edge after reset release
  p_reset_quiet_r10: assert property (@(posedge clk)
    $rose(rst_n) |-> (slot_req == '0) && (irq_ack == '0) && !rsp_valid);
endmodule

bind mezz_slot_decoder mezz_slot_decoder_chk #(
  .NUM_SLOTS (NUM_SLOTS),
  .DATA_W    (DATA_W),
  .OFF_W     (OFF_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_write    (req_write),
  .req_size     (req_size),
  .slot_present (slot_present),
  .slot_req     (slot_req),
  .slot_space   (slot_space),
  .slot_offset  (slot_offset),
  .slot_write   (slot_write),
  .irq_ack      (irq_ack),
  .rsp_valid    (rsp_valid)
);

// File: tb/mezz_slot_decoder_tb.sv
`timescale 1ns/1ps
module mezz_slot_decoder_tb;
  localparam int NS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [9:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        big_endian = 1'b0;
  logic [3:0]  slot_present = 4'hF;
  logic [7:0]  irq_status = '0;
  logic [7:0]  irq_edge = '0;
  logic [63:0] slot_rdata;
  logic [3:0]  slot_req;
  logic [1:0]  slot_space;
  logic [6:0]  slot_offset;
  logic        slot_write;
  logic        slot_half;
  logic [15:0] slot_wdata;
  logic [7:0]  irq_ack;
  logic        rsp_valid;
  logic [15:0] rsp_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mezz_slot_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .big_endian(big_endian), .slot_present(slot_present),
    .irq_status(irq_status), .irq_edge(irq_edge), .slot_rdata(slot_rdata),
    .slot_req(slot_req), .slot_space(slot_space), .slot_offset(slot_offset),
    .slot_write(slot_write), .slot_half(slot_half), .slot_wdata(slot_wdata),
    .irq_ack(irq_ack), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  // slot model: read data is a pattern of slot, space and offset
  function automatic logic [15:0] pat(input int s, input logic [1:0] sp, input logic [6:0] off);
    return {4'hA, s[1:0], sp, 1'b0, off};
  endfunction

  always_comb begin
    for (int s = 0; s < NS; s++) slot_rdata[s*16 +: 16] = pat(s, slot_space, slot_offset);
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // one access with full expectation computed from the requirements
  task automatic access(input logic wr, input logic [1:0] sz, input logic [9:0] a,
                        input logic [15:0] wd);
    logic [9:0]  ea;
    int          s;
    logic [1:0]  sp;
    logic [6:0]  off;
    logic        ok, live;
    logic [3:0]  e_req;
    logic [7:0]  e_ack;
    logic [15:0] e_rd, e_wd;
    int          idx;
    ea   = a ^ {9'd0, (big_endian && sz == 2'd0)};        // R8
    s    = int'(ea[9:8]);
    sp   = (ea[7:6] == 2'd2) ? 2'd1 : (ea[7:6] == 2'd3) ? 2'd2 : 2'd0;   // R2
    off  = (sp == 2'd0) ? ea[6:0] : {1'b0, ea[5:0]};       // R3
    ok   = (sz < 2'd2);                                     // R7
    live = ok && slot_present[s];                            // R6
    e_req = live ? (4'b1 << s) : 4'b0;
    e_ack = '0;
    if (live && !wr && sp == 2'd2 && (off == 7'd0 || off == 7'd2)) begin
      idx = s*2 + int'(off[1]);
      if (irq_status[idx] && !irq_edge[idx]) e_ack[idx] = 1'b1;   // R5
    end
    e_wd = (big_endian && sz == 2'd1) ? {wd[7:0], wd[15:8]} : wd;  // R9
    e_rd = pat(s, sp, off);
    if (big_endian && sz == 2'd1) e_rd = {e_rd[7:0], e_rd[15:8]};  // R9
    if (!live) e_rd = '0;                                           // R6, R7
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1", "slot_req", 32'(slot_req), 32'(e_req));
    chk("R5", "irq_ack", 32'(irq_ack), 32'(e_ack));
    if (live) begin
      chk("R2", "slot_space", 32'(slot_space), 32'(sp));
      chk("R3", "slot_offset", 32'(slot_offset), 32'(off));
      chk("R4", "slot_write", 32'(slot_write), 32'(wr));
      chk("R9", "slot_half", 32'(slot_half), 32'(sz == 2'd1));
      if (wr) chk("R9", "slot_wdata", 32'(slot_wdata), 32'(e_wd));
    end
    @(negedge clk);
    chk("R4", "rsp_valid", 32'(rsp_valid), 32'(!wr));
    if (!wr) chk("R4", "rsp_data", 32'(rsp_data), 32'(e_rd));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R10: request during reset is dropped
    req_valid = 1'b1; req_addr = 10'h0C0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10", "slot_req in reset", 32'(slot_req), 0);
    chk("R10", "rsp_valid in reset", 32'(rsp_valid), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "slot_req after reset", 32'(slot_req), 0);
    chk("R10", "irq_ack after reset", 32'(irq_ack), 0);
    @(negedge clk);
    chk("R10", "rsp_valid after reset", 32'(rsp_valid), 0);

    // sweep reads: every address, both endian modes, all size codes
    for (int be = 0; be < 2; be++) begin
      for (int sz = 0; sz < 4; sz++) begin
        big_endian   = be[0];
        slot_present = be[0] ? 4'b0111 : 4'b1011;
        for (int a = 0; a < 1024; a++) begin
          irq_status = 8'(a >> 2) ^ 8'hC3;
          irq_edge   = 8'(a >> 4) ^ 8'h5A;
          access(1'b0, 2'(sz), 10'(a), 16'h0);
        end
      end
    end

    // sweep writes
    for (int be = 0; be < 2; be++) begin
      big_endian = be[0];
      slot_present = 4'b1101;
      for (int a = 0; a < 1024; a += 7) begin
        for (int sz = 0; sz < 3; sz++) access(1'b1, 2'(sz), 10'(a), 16'(a * 291) ^ 16'h5AC3);
      end
    end

    // directed R5 corner cases, slot 2 interrupt space at 0x2C0
    big_endian = 1'b0; slot_present = 4'hF;
    irq_status = 8'b0011_0000; irq_edge = 8'h00;
    access(1'b0, 2'd1, 10'h2C0, 16'h0);    // R5 ack line 0
    access(1'b0, 2'd1, 10'h2C2, 16'h0);    // R5 ack line 1
    access(1'b0, 2'd0, 10'h2C1, 16'h0);    // R5 offset 1: none
    access(1'b1, 2'd1, 10'h2C0, 16'h1234); // R5 write: none
    irq_edge = 8'b0001_0000;
    access(1'b0, 2'd1, 10'h2C0, 16'h0);    // R5 edge line: none
    irq_status = 8'b0000_0000; irq_edge = 8'h00;
    access(1'b0, 2'd1, 10'h2C2, 16'h0);    // R5 status clear: none
    big_endian = 1'b1; irq_status = 8'hFF;
    access(1'b0, 2'd0, 10'h2C1, 16'h0);    // R8 flipped byte hits offset 0
    slot_present = 4'b1011;
    access(1'b0, 2'd1, 10'h2C0, 16'h0);    // R6 absent: no ack, zero data

    finish_run();
  end
endmodule